// File: doc/BRIEF.md
# Split Rounding Multiplier

This block is a two-stage pipelined integer multiplier. It takes one 32-bit operand word that holds two 16-bit halfwords. In single mode it multiplies the two halfwords and returns one 32-bit product. In dual mode it multiplies the two low bytes and the two high bytes as two separate 8×8 products, and packs the two 16-bit results into the 32-bit output.

A set of control bits arrives with each operation and is registered with it. These bits choose the mode, signed or unsigned operands, a fractional doubling with saturation, and rounding to the upper half of each product. Either mode can use any combination of these options. One array of four byte-by-byte partial products serves both modes.

The block cannot stall. A result appears exactly two cycles after its operand was accepted, and a new operation can be issued on every cycle.

Top module: `split_round_mul`

## Requirements
- R1: The operand word is laid out as `op[15:0]` = X and `op[31:16]` = Y. In dual mode, lane 0 multiplies `op[7:0]` by `op[23:16]` and lane 1 multiplies `op[15:8]` by `op[31:24]`.
- R2: When `dual`=0, `frac`=0 and `rnd`=0, `result` equals X×Y as a 32-bit value. X and Y are two's-complement when `sgn`=1 and unsigned when `sgn`=0.
- R3: When `dual`=1, `frac`=0 and `rnd`=0:
  - `result[15:0]` holds the lane 0 product.
  - `result[31:16]` holds the lane 1 product.
  - Bytes are signed when `sgn`=1.
  - A carry or sign never crosses between lanes.
- R4: When `frac`=1 and `sgn`=1, each product is shifted left by one bit, wrapping within its field. When `sgn`=0, `frac` has no effect.
- R5: When `sgn`=1 and `frac`=1, a product of the most negative value by itself saturates to the largest positive value of its field. That value is 0x7FFFFFFF in single mode and 0x7FFF per lane in dual mode.
- R6: When `rnd`=1 in single mode, `result` is ((P + 0x8000) >> 16) zero-extended to 32 bits, where P is the 32-bit value after R4/R5. A saturated product gives 0x00007FFF.
- R7: When `rnd`=1 in dual mode, each 16-bit lane field holds ((P + 0x80) >> 8) in its low byte and zero in its high byte. A saturated lane gives 0x007F.
- R8: `out_valid` is high in exactly the cycles two clock edges after `in_valid` was sampled high. Back-to-back operations are accepted without a gap.
- R9: While `rst_n` is low and on the first edges after it is released, `out_valid` is low. This holds whatever `in_valid` did during reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operand word and controls are valid this cycle |
| op | input | 32 | Packed operand halfwords {Y, X} |
| dual | input | 1 | 1: two 8×8 products, 0: one 16×16 product |
| sgn | input | 1 | Operands are two's-complement |
| frac | input | 1 | Fractional doubling with saturation (signed only) |
| rnd | input | 1 | Round and return the upper half of each product |
| out_valid | output | 1 | Result is valid |
| result | output | 32 | Product, packed lanes or rounded upper halves |

## Verification
The assertions check three behaviours on every cycle:
- the two-cycle link between `in_valid` and `out_valid`, in both directions;
- the zero upper bytes of every rounded result, single and dual;
- the saturated word for the signed most-negative square.

The arithmetic itself can only be shown by the bench's scenarios:
- correct signed and unsigned products;
- lane isolation under sign extension;
- wrapping of the fractional shift;
- the rounding carry into the kept half.

The bench compares these against a behavioural model over random operands mixed with extreme byte values.

// File: rtl/split_round_mul.sv
module split_round_mul #(
  parameter int LW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  input  logic [4*LW-1:0] op,
  input  logic            dual,
  input  logic            sgn,
  input  logic            frac,
  input  logic            rnd,
  output logic            out_valid,
  output logic [4*LW-1:0] result
);
  localparam int HW = 2 * LW;
  localparam int OW = 4 * LW;
  localparam int PW = 2 * LW + 2;

  logic [LW-1:0] xl, xh, yl, yh;
  assign xl = op[LW-1:0];
  assign xh = op[HW-1:LW];
  assign yl = op[HW+LW-1:HW];
  assign yh = op[OW-1:HW+LW];

  // low bytes carry a sign only when they are lane operands
  logic ext_lo;
  assign ext_lo = sgn & dual;

  logic signed [LW:0] xl_e, xh_e, yl_e, yh_e;
  assign xl_e = $signed({ext_lo & xl[LW-1], xl});
  assign yl_e = $signed({ext_lo & yl[LW-1], yl});
  assign xh_e = $signed({sgn & xh[LW-1], xh});
  assign yh_e = $signed({sgn & yh[LW-1], yh});

  logic signed [PW-1:0] pp_ll, pp_lh, pp_hl, pp_hh;
  logic v1, d1, s1, f1, r1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      v1 <= 1'b0;
      {d1, s1, f1, r1} <= '0;
      pp_ll <= '0;
      pp_lh <= '0;
      pp_hl <= '0;
      pp_hh <= '0;
    end else begin
      v1 <= in_valid;
      if (in_valid) begin
        {d1, s1, f1, r1} <= {dual, sgn, frac, rnd};
        pp_ll <= xl_e * yl_e;
        pp_lh <= xl_e * yh_e;
        pp_hl <= xh_e * yl_e;
        pp_hh <= xh_e * yh_e;
      end
    end
  end

  logic signed [OW-1:0] ll_x, lh_x, hl_x, hh_x, wide;
  assign ll_x = OW'(pp_ll);
  assign lh_x = OW'(pp_lh);
  assign hl_x = OW'(pp_hl);
  assign hh_x = OW'(pp_hh);
  assign wide = (hh_x <<< HW) + ((lh_x + hl_x) <<< LW) + ll_x;

  function automatic logic [OW-1:0] shape(input logic [OW-1:0] p, input int unsigned n,
                                          input logic s, input logic f, input logic r);
    logic [OW-1:0] full_m, half_m, top, q, sum;
    logic sat;
    full_m = {OW{1'b1}} >> (OW - 2 * n);
    half_m = {OW{1'b1}} >> (OW - n);
    top    = OW'(1) << (2 * n - 2);
    sat    = s & f & ((p & full_m) == top);
    if (sat)        q = full_m >> 1;
    else if (s & f) q = (p << 1) & full_m;
    else            q = p & full_m;
    sum = (q + (OW'(1) << (n - 1))) & full_m;
    if (!r)       return q;
    else if (sat) return half_m >> 1;
    else          return (sum >> n) & half_m;
  endfunction

  logic [OW-1:0] res_n, sh_s, sh_l0, sh_l1;
  always_comb begin
    sh_s  = shape(wide, HW, s1, f1, r1);
    sh_l0 = shape({{HW{1'b0}}, pp_ll[HW-1:0]}, LW, s1, f1, r1);
    sh_l1 = shape({{HW{1'b0}}, pp_hh[HW-1:0]}, LW, s1, f1, r1);
    res_n = d1 ? {sh_l1[HW-1:0], sh_l0[HW-1:0]} : sh_s;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      result    <= '0;
    end else begin
      out_valid <= v1;
      if (v1) result <= res_n;
    end
  end

  AST_LATENCY_ON: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |-> ##2 out_valid); // R8
  AST_LATENCY_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |-> ##2 !out_valid); // R8
  AST_RND_SINGLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(rnd && !dual, 2)) |-> (result[OW-1:HW] == '0)); // R6
  AST_RND_DUAL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(rnd && dual, 2)) |->
      (result[OW-1:OW-LW] == '0 && result[HW-1:LW] == '0)); // R7
  AST_SAT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(sgn && frac && !dual && !rnd &&
       op == {1'b1, {(HW-1){1'b0}}, 1'b1, {(HW-1){1'b0}}}, 2)) |->
      (result == {1'b0, {(OW-1){1'b1}}})); // R5
endmodule

// File: tb/tb_split_round_mul.sv
module tb_split_round_mul;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [31:0] op = '0;
  logic dual = 1'b0, sgn = 1'b0, frac = 1'b0, rnd = 1'b0;
  logic out_valid;
  logic [31:0] result;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic pv[2];
  logic [31:0] pe[2];
  string ptag[2];

  always #10 clk = ~clk;

  split_round_mul dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op), .dual(dual),
    .sgn(sgn), .frac(frac), .rnd(rnd), .out_valid(out_valid), .result(result)
  );

  function automatic longint fld(input longint xa, input longint ya, input int n,
                                 input bit s, input bit f, input bit r);
    longint xv, yv, p, q;
    bit sat;
    xv = (s && xa[n-1]) ? xa - (64'sd1 <<< n) : xa;
    yv = (s && ya[n-1]) ? ya - (64'sd1 <<< n) : ya;
    p = xv * yv;
    sat = 0;
    if (s && f) begin
      if (p == (64'sd1 <<< (2*n-2))) begin
        sat = 1;
        q = (64'sd1 <<< (2*n-1)) - 1;
      end else q = p * 2;
    end else q = p;
    if (r) begin
      if (sat) return (64'sd1 <<< (n-1)) - 1;
      return ((q + (64'sd1 <<< (n-1))) >>> n) & ((64'sd1 <<< n) - 1);
    end
    return q & ((64'sd1 <<< (2*n)) - 1);
  endfunction

  function automatic logic [31:0] model(input logic [31:0] o, input bit d, input bit s,
                                        input bit f, input bit r);
    longint a, b;
    if (!d) begin
      a = fld(longint'(o[15:0]), longint'(o[31:16]), 16, s, f, r);
      return a[31:0];
    end
    a = fld(longint'(o[7:0]), longint'(o[23:16]), 8, s, f, r);
    b = fld(longint'(o[15:8]), longint'(o[31:24]), 8, s, f, r);
    return {b[15:0], a[15:0]};
  endfunction

  function automatic string tagof(input logic [31:0] o, input bit d, input bit s,
                                  input bit f, input bit r);
    if (r) return d ? "R7" : "R6";
    if (s && f && !d && o == 32'h8000_8000) return "R5";
    if (s && f && d && (o[7:0] == 8'h80 && o[23:16] == 8'h80)) return "R5";
    if (f) return "R4";
    return d ? "R1,R3" : "R1,R2";
  endfunction

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cycle(input bit v, input logic [31:0] o, input bit d, input bit s,
                       input bit f, input bit r);
    @(negedge clk);
    check(out_valid == pv[1], "R8", {31'd0, out_valid}, {31'd0, pv[1]});
    if (pv[1]) check(result == pe[1], ptag[1], result, pe[1]);
    pv[1] = pv[0]; pe[1] = pe[0]; ptag[1] = ptag[0];
    pv[0] = v; pe[0] = model(o, d, s, f, r); ptag[0] = tagof(o, d, s, f, r);
    in_valid = v; op = o; dual = d; sgn = s; frac = f; rnd = r;
  endtask

  function automatic logic [7:0] pick_byte();
    case ($urandom_range(0, 7))
      0: return 8'h80;
      1: return 8'h7F;
      2: return 8'hFF;
      3: return 8'h00;
      default: return 8'($urandom);
    endcase
  endfunction

  initial begin
    void'($urandom(32'd1234));
    pv[0] = 0; pv[1] = 0; pe[0] = '0; pe[1] = '0; ptag[0] = ""; ptag[1] = "";
    in_valid = 1'b1;
    op = 32'h8000_8000;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check(out_valid == 1'b0, "R9", {31'd0, out_valid}, 32'd0);
    end
    in_valid = 1'b0;
    rst_n = 1'b1;
    // directed corners: sign handling, saturation, rounding carry, lane isolation
    cycle(1, 32'h8000_8000, 0, 1, 1, 0);
    cycle(1, 32'h8000_8000, 0, 1, 1, 1);
    cycle(1, 32'h8080_8080, 1, 1, 1, 0);
    cycle(1, 32'h8080_8080, 1, 1, 1, 1);
    cycle(1, 32'hFFFF_FFFF, 0, 0, 0, 0);
    cycle(1, 32'hFFFF_FFFF, 0, 1, 0, 0);
    cycle(1, 32'hFFFF_FFFF, 0, 0, 1, 0);
    cycle(1, 32'hFFFF_FFFF, 1, 0, 0, 0);
    cycle(1, 32'hFFFF_FFFF, 1, 1, 0, 0);
    cycle(0, 32'h0, 0, 0, 0, 0);
    cycle(1, 32'h0001_8000, 0, 1, 0, 1);
    cycle(1, 32'h7FFF_8000, 0, 1, 1, 1);
    cycle(1, 32'hFF01_80FF, 1, 1, 0, 1);
    cycle(1, 32'h7F80_7F80, 1, 1, 1, 0);
    cycle(1, 32'h00FF_00FF, 0, 0, 0, 1);
    cycle(0, 32'h0, 0, 0, 0, 0);
    cycle(0, 32'h0, 0, 0, 0, 0);
    for (int i = 0; i < 2000; i++) begin
      logic [31:0] o;
      o = {pick_byte(), pick_byte(), pick_byte(), pick_byte()};
      cycle($urandom_range(0, 4) != 0, o, 1'($urandom), 1'($urandom),
            1'($urandom), 1'($urandom));
    end
    cycle(0, 32'h0, 0, 0, 0, 0);
    cycle(0, 32'h0, 0, 0, 0, 0);
    cycle(0, 32'h0, 0, 0, 0, 0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule